// File: doc/BRIEF.md
# Read Protection Level Controller

This block keeps the read-protection option byte of an embedded flash and turns it into one of three protection levels. The byte value 0xAA selects level 0 (open), 0xCC selects level 2 (locked for good), and every other value selects level 1 (protected). The block decides whether a requested change to that byte may take effect. It also decides, for each incoming memory access, whether the access is granted or denied.

A change from level 1 down to level 0 is not applied directly. The block first raises a mass-erase request and holds the new byte in a pending register. It commits that byte only when the erase engine returns a done pulse. While that erase runs, every access is denied. Level 2 cannot be left: every later option write is rejected. At level 2 the block also drives the outputs that disable debug and block booting from system memory.

Top module: `rdp_level_ctrl`

## Requirements
- R1: `cur_level` reports 0 when the held byte is 0xAA, 2 when it is 0xCC, and 1 for any other value.
- R2: While `rst_n` is low, the held byte is loaded from `boot_byte` on each rising clock edge. After release, the level is the one decoded from that byte.
- R3: A write at level 1 whose new byte decodes to level 0 raises `erase_req` from the next cycle. The held byte stays unchanged until `erase_done` is seen. On that edge the new byte is committed, `erase_req` falls and `wr_ack` pulses for one cycle.
- R4: A write at level 0, or a write at level 1 to level 1 or level 2, commits the new byte on the sampling edge with a one-cycle `wr_ack` pulse and no erase request.
- R5: At level 2 every write is rejected with a one-cycle `wr_rej` pulse, the held byte is unchanged, and the level never leaves 2.
- R6: `dbg_disable` and `sysboot_block` are high exactly when the level is 2.
- R7: At level 1, every requested access is denied when `dbg_conn` or `boot_alt` is high.
- R8: Outside an erase, accesses are granted at level 0 whatever the status inputs. At level 1 they are granted when both status inputs are low. At level 2 they are granted when `boot_alt` is low, regardless of `dbg_conn`.
- R9: While `erase_req` is high, every requested access is denied. A write arriving without `erase_done` is rejected with `wr_rej`.
- R10: For each access kind (bit 0 read, bit 1 program, bit 2 erase), grant and deny are never both high. Neither is high unless that request bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the held byte |
| boot_byte | input | 8 | Stored protection byte loaded during reset |
| wr_req | input | 1 | Option write request |
| wr_byte | input | 8 | New protection byte for the write |
| wr_ack | output | 1 | One-cycle pulse: new byte committed |
| wr_rej | output | 1 | One-cycle pulse: write rejected |
| erase_req | output | 1 | Mass-erase request, held until done |
| erase_done | input | 1 | Mass-erase completion pulse |
| dbg_conn | input | 1 | Debug probe connected |
| boot_alt | input | 1 | Device booted from RAM or system memory |
| acc_req | input | 3 | Access request per kind: bit 0 read, bit 1 program, bit 2 erase |
| acc_grant | output | 3 | Access granted per kind |
| acc_deny | output | 3 | Access denied per kind |
| dbg_disable | output | 1 | Debug disabled (level 2) |
| sysboot_block | output | 1 | Boot from system memory blocked (level 2) |
| cur_level | output | 2 | Decoded protection level |
| cur_byte | output | 8 | Held protection byte |

## Verification
The hardest situation to reach is the window inside a level-1-to-0 downgrade. In that window the erase request is pending, the held byte must not yet change, accesses must be refused, and a second write must be turned away. The stimulus reaches it by resetting at a level-1 byte and writing 0xAA. It then holds `erase_done` low for several cycles while it issues accesses under every status combination and one further write, and only then pulses the done input. Level 2 is reached both from reset and through a live 1-to-2 write, so that the one-way lock is checked from both entry paths.

// File: rtl/rdp_level_ctrl.sv
module rdp_level_ctrl #(
  parameter int BW = 8,
  parameter int NKIND = 3,
  parameter logic [BW-1:0] OPEN_CODE = 8'hAA,
  parameter logic [BW-1:0] LOCK_CODE = 8'hCC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BW-1:0]    boot_byte,
  input  logic             wr_req,
  input  logic [BW-1:0]    wr_byte,
  output logic             wr_ack,
  output logic             wr_rej,
  output logic             erase_req,
  input  logic             erase_done,
  input  logic             dbg_conn,
  input  logic             boot_alt,
  input  logic [NKIND-1:0] acc_req,
  output logic [NKIND-1:0] acc_grant,
  output logic [NKIND-1:0] acc_deny,
  output logic             dbg_disable,
  output logic             sysboot_block,
  output logic [1:0]       cur_level,
  output logic [BW-1:0]    cur_byte
);

  function automatic logic [1:0] decode(input logic [BW-1:0] b);
    if (b == OPEN_CODE)      return 2'd0;
    else if (b == LOCK_CODE) return 2'd2;
    else                     return 2'd1;
  endfunction

  logic [BW-1:0] byte_q, pend_q;
  logic          busy_q, ack_q, rej_q;
  logic [1:0]    lvl, new_lvl;
  logic          open_ok;

  assign lvl     = decode(byte_q);
  assign new_lvl = decode(wr_byte);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_q <= boot_byte;
      pend_q <= '0;
      busy_q <= 1'b0;
      ack_q  <= 1'b0;
      rej_q  <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      rej_q <= 1'b0;
      if (busy_q) begin
        if (erase_done) begin
          byte_q <= pend_q;
          busy_q <= 1'b0;
          ack_q  <= 1'b1;
        end else if (wr_req) begin
          rej_q <= 1'b1;
        end
      end else if (wr_req) begin
        if (lvl == 2'd2) begin
          rej_q <= 1'b1;
        end else if (lvl == 2'd1 && new_lvl == 2'd0) begin
          pend_q <= wr_byte;
          busy_q <= 1'b1;
        end else begin
          byte_q <= wr_byte;
          ack_q  <= 1'b1;
        end
      end
    end
  end

  assign open_ok       = (lvl == 2'd0) | (!boot_alt & ((lvl == 2'd2) | !dbg_conn));
  assign acc_grant     = (busy_q || !open_ok) ? '0 : acc_req;
  assign acc_deny      = acc_req & ~acc_grant;
  assign erase_req     = busy_q;
  assign wr_ack        = ack_q;
  assign wr_rej        = rej_q;
  assign dbg_disable   = (lvl == 2'd2);
  assign sysboot_block = (lvl == 2'd2);
  assign cur_level     = lvl;
  assign cur_byte      = byte_q;

  assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_level == 2'd2) |=> (cur_level == 2'd2));
  assert_lock_rejects_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!erase_req && cur_level == 2'd2 && wr_req) |=> (wr_rej && $stable(cur_byte)));
  assert_down_erases_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!erase_req && cur_level == 2'd1 && wr_req && wr_byte == OPEN_CODE) |=> (erase_req && $stable(cur_byte)));
  assert_erase_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_req && !erase_done) |=> $stable(cur_byte));
  assert_erase_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> (acc_grant == '0));
  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_grant & acc_deny) == '0) && (((acc_grant | acc_deny) & ~acc_req) == '0));
  assert_l1_debug_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_level == 2'd1 && (dbg_conn || boot_alt)) |-> (acc_grant == '0));
  assert_pulse_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ack && wr_rej));

endmodule

// File: tb/rdp_level_ctrl_tb.sv
module rdp_level_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] boot_byte = 8'h55;
  logic       wr_req = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic       wr_ack, wr_rej, erase_req;
  logic       erase_done = 1'b0;
  logic       dbg_conn = 1'b0;
  logic       boot_alt = 1'b0;
  logic [2:0] acc_req = 3'b000;
  logic [2:0] acc_grant, acc_deny;
  logic       dbg_disable, sysboot_block;
  logic [1:0] cur_level;
  logic [7:0] cur_byte;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  int m_byte = 8'h55, m_pend = 0;
  bit m_busy = 0, m_ack = 0, m_rej = 0;

  always #10 clk = ~clk;

  rdp_level_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .boot_byte(boot_byte),
    .wr_req(wr_req), .wr_byte(wr_byte), .wr_ack(wr_ack), .wr_rej(wr_rej),
    .erase_req(erase_req), .erase_done(erase_done),
    .dbg_conn(dbg_conn), .boot_alt(boot_alt),
    .acc_req(acc_req), .acc_grant(acc_grant), .acc_deny(acc_deny),
    .dbg_disable(dbg_disable), .sysboot_block(sysboot_block),
    .cur_level(cur_level), .cur_byte(cur_byte)
  );

  function automatic int lv(input int b);
    if (b == 8'hAA) return 0;
    if (b == 8'hCC) return 2;
    return 1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_byte = boot_byte; m_busy = 0; m_ack = 0; m_rej = 0;
    end else begin
      m_ack = 0; m_rej = 0;
      if (m_busy) begin
        if (erase_done) begin m_byte = m_pend; m_busy = 0; m_ack = 1; end
        else if (wr_req) m_rej = 1;
      end else if (wr_req) begin
        if (lv(m_byte) == 2) m_rej = 1;
        else if (lv(m_byte) == 1 && lv(wr_byte) == 0) begin m_busy = 1; m_pend = wr_byte; end
        else begin m_byte = wr_byte; m_ack = 1; end
      end
    end
    #5;
    if (rst_n && !done) begin
      int l;
      bit ok;
      string at;
      l = lv(m_byte);
      ok = !m_busy && (l == 0 || (!boot_alt && (l == 2 || !dbg_conn)));
      at = m_busy ? "R9" : (l == 1 && (dbg_conn || boot_alt)) ? "R7" : "R8";
      chk("R1 level", cur_level, l);
      chk("R3 byte", cur_byte, m_byte);
      chk("R3 erase_req", erase_req, m_busy);
      chk("R4 wr_ack", wr_ack, m_ack);
      chk("R5 wr_rej", wr_rej, m_rej);
      chk("R6 dbg_disable", dbg_disable, l == 2);
      chk("R6 sysboot_block", sysboot_block, l == 2);
      chk({at, " grant"}, acc_grant, ok ? acc_req : 3'b000);
      chk({at, " deny R10"}, acc_deny, ok ? 3'b000 : acc_req);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [7:0] b);
    @(negedge clk);
    rst_n = 0; boot_byte = b;
    cyc(3);
    rst_n = 1;
    cyc(1);
  endtask

  task automatic write(input logic [7:0] b);
    wr_req = 1; wr_byte = b;
    cyc(1);
    wr_req = 0;
    cyc(1);
  endtask

  task automatic sweep();
    for (int s = 0; s < 4; s++) begin
      dbg_conn = s[0]; boot_alt = s[1];
      for (int k = 1; k < 8; k += 3) begin
        acc_req = k[2:0];
        cyc(1);
      end
    end
    dbg_conn = 0; boot_alt = 0; acc_req = 0;
  endtask

  initial begin
    do_reset(8'h55);
    chk("R2 reset level", cur_level, 1);
    chk("R2 reset byte", cur_byte, 8'h55);
    sweep();
    write(8'h5A);
    write(8'hAA);
    chk("R3 erase pending", erase_req, 1);
    chk("R3 byte held", cur_byte, 8'h5A);
    sweep();
    write(8'h77);
    cyc(2);
    erase_done = 1; cyc(1); erase_done = 0;
    chk("R3 committed", cur_level, 0);
    sweep();
    write(8'h12);
    sweep();
    write(8'hCC);
    chk("R4 raised to 2", cur_level, 2);
    sweep();
    write(8'hAA);
    write(8'h33);
    chk("R5 still locked", cur_byte, 8'hCC);
    do_reset(8'hAA);
    chk("R2 reset open", cur_level, 0);
    write(8'hCC);
    chk("R4 zero to two", cur_level, 2);
    do_reset(8'hCC);
    chk("R2 reset locked", cur_level, 2);
    write(8'hAA);
    sweep();
    cyc(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule